// File: doc/BRIEF.md
# Edge-Triggered One-Shot Down-Counter

This block is a single timer channel that measures out one delay after an external event. Software first arms the channel with a start strobe. The channel then waits, with its counter held, for a rising edge on an asynchronous trigger input. When the edge is seen, the counter loads the reload value and counts down by one on each count-clock tick.

When a tick arrives while the counter is at zero, the block raises an interrupt for one clock cycle. The counter then parks at all-ones and the channel waits for the next trigger edge. No further software action is needed to re-arm it.

The trigger input always passes through a synchronizer clocked by the count tick. A runtime-selectable filter can also be switched in. It rejects a level that does not stay stable across two more ticks, and it delays detection by exactly two ticks. A stop strobe disarms the channel and freezes the counter.

Top module: `edge_oneshot_timer`

## Requirements
- R1: Reset (synchronous, active high) sets `count_q` to 0000h, `enabled` to 0 and `irq` to 0.
- R2: A start strobe on a disabled channel sets `enabled` to 1. While the channel waits for a trigger, `count_q` keeps its value across count ticks.
- R3: With `filt_en` = 0, a trigger level that goes from 0 to 1 before count tick 1 is detected at tick 2. At that tick `count_q` takes the value of `reload`.
- R4: After a load, each count tick lowers `count_q` by one. Clock cycles without a tick leave `count_q` unchanged.
- R5: A count tick taken while a count is running and `count_q` is 0000h has three effects. `irq` is 1 for exactly that one following clock cycle, `count_q` becomes FFFFh, and `enabled` stays 1.
- R6: With `filt_en` = 1, the same trigger edge is detected two ticks later, at tick 4, where `count_q` takes `reload`.
- R7: With `filt_en` = 1, a trigger high level that lasts only one tick causes no load.
- R8: Rising trigger edges during a running count are ignored, and counting continues.
- R9: After the counter parks at FFFFh, the next rising edge reloads it and a new count begins.
- R10: A stop strobe clears `enabled` and freezes `count_q` against ticks and edges. A later start strobe while the trigger is already high does not load; a fresh rising edge is needed.
- R11: With `reload` = 0000h, `irq` fires on the first count tick after the load, and then `count_q` parks at FFFFh.
- R12: A start strobe while the channel is enabled has no effect on the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable, one clk cycle wide |
| start_wr | input | 1 | Start write strobe (arms the channel) |
| stop_wr | input | 1 | Stop write strobe (disarms the channel, takes priority over start) |
| reload | input | 16 | Value loaded on a trigger |
| trig_async | input | 1 | Asynchronous external trigger input |
| filt_en | input | 1 | Switches in the two-tick trigger filter |
| count_q | output | 16 | Current counter value |
| enabled | output | 1 | Channel enable status |
| irq | output | 1 | Interrupt pulse at the end of a count |

## Verification
A vector table runs through reload values 0, 1, 3 and 7, each with the filter off and on. This tells a two-tick detection latency apart from a four-tick one, and a zero-length count apart from a longer one. Back-to-back rows also show that a parked channel re-arms by itself.

Directed sequences cover the remaining patterns:
- A one-tick glitch under the filter, which separates a filtered input from a plain synchronized one.
- A trigger toggled during a count, which shows whether edges restart a running count.
- Stop, then start while the trigger is already high, which separates level sensing from true edge detection.
- A start strobe during a count, followed by a reset mid-count.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    localparam int unsigned CNT_W_DEF  = 16;
    localparam int unsigned SYNC_N_DEF = 2;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_RUN  = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic rise_raw;
        logic rise_filt;
    } edge_flags_s;

    function automatic logic pick_rise(input edge_flags_s f, input logic use_filt);
        return use_filt ? f.rise_filt : f.rise_raw;
    endfunction

endpackage

// File: rtl/os_trig_sync.sv
module os_trig_sync
    import oneshot_pkg::*;
#(
    parameter int unsigned SYNC_N = SYNC_N_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic trig_async,
    input  logic filt_en,
    output logic rise
);
    logic [SYNC_N-1:0] sq;
    logic              hist;
    logic              flt_lvl;
    edge_flags_s       flags;

    for (genvar i = 0; i < SYNC_N; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)       sq[i] <= 1'b0;
                else if (tick) sq[i] <= trig_async;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)       sq[i] <= 1'b0;
                else if (tick) sq[i] <= sq[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist    <= 1'b0;
            flt_lvl <= 1'b0;
        end else if (tick) begin
            hist <= sq[SYNC_N-1];
            if (sq[SYNC_N-1] == hist)
                flt_lvl <= hist;
        end
    end

    always_comb begin
        flags.rise_raw  = sq[SYNC_N-2] & ~sq[SYNC_N-1];
        flags.rise_filt = sq[SYNC_N-1] & hist & ~flt_lvl;
        rise            = tick & pick_rise(flags, filt_en);
    end

endmodule

// File: rtl/os_counter.sv
module os_counter
    import oneshot_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start_wr,
    input  logic             stop_wr,
    input  logic             rise,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             enabled,
    output logic             irq
);
    localparam logic [CNT_W-1:0] PARK = '1;
    localparam logic [CNT_W-1:0] ZERO = '0;

    ch_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CH_OFF;
            count <= ZERO;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (stop_wr) begin
                st <= CH_OFF;
            end else begin
                case (st)
                    CH_OFF: begin
                        if (start_wr) st <= CH_WAIT;
                    end
                    CH_WAIT: begin
                        if (rise) begin
                            count <= reload;
                            st    <= CH_RUN;
                        end
                    end
                    CH_RUN: begin
                        if (tick) begin
                            if (count == ZERO) begin
                                count <= PARK;
                                irq   <= 1'b1;
                                st    <= CH_WAIT;
                            end else begin
                                count <= count - 1'b1;
                            end
                        end
                    end
                    default: st <= CH_OFF;
                endcase
            end
        end
    end

    assign enabled = (st != CH_OFF);

endmodule

// File: rtl/edge_oneshot_timer.sv
module edge_oneshot_timer
    import oneshot_pkg::*;
#(
    parameter int unsigned CNT_W  = CNT_W_DEF,
    parameter int unsigned SYNC_N = SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start_wr,
    input  logic             stop_wr,
    input  logic [CNT_W-1:0] reload,
    input  logic             trig_async,
    input  logic             filt_en,
    output logic [CNT_W-1:0] count_q,
    output logic             enabled,
    output logic             irq
);
    logic rise;

    os_trig_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .trig_async (trig_async),
        .filt_en    (filt_en),
        .rise       (rise)
    );

    os_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .start_wr (start_wr),
        .stop_wr  (stop_wr),
        .rise     (rise),
        .reload   (reload),
        .count    (count_q),
        .enabled  (enabled),
        .irq      (irq)
    );

endmodule

// File: rtl/os_assert.sv
module os_assert #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             stop_wr,
    input logic [CNT_W-1:0] count_q,
    input logic             enabled,
    input logic             irq
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count_q == '0 && !enabled && !irq));

    a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r5_irq_parks: assert property (@(posedge clk) disable iff (rst)
        irq |-> (count_q == '1 && enabled));

    a_r5_irq_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(tick));

    a_r10_stop_clears: assert property (@(posedge clk) disable iff (rst)
        stop_wr |=> !enabled);

    a_r10_frozen_off: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> $stable(count_q));

endmodule

bind edge_oneshot_timer os_assert #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .stop_wr (stop_wr),
    .count_q (count_q),
    .enabled (enabled),
    .irq     (irq)
);

// File: tb/sim_edge_oneshot_timer.sv
`timescale 1ns/1ps
module sim_edge_oneshot_timer;

    typedef struct packed {
        logic        filt;
        logic [15:0] rld;
        logic [3:0]  load_tk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b0, 16'd3, 4'd2},
        '{1'b1, 16'd3, 4'd4},
        '{1'b0, 16'd0, 4'd2},
        '{1'b1, 16'd1, 4'd4},
        '{1'b0, 16'd7, 4'd2},
        '{1'b1, 16'd0, 4'd4},
        '{1'b0, 16'd1, 4'd2},
        '{1'b1, 16'd7, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst, tick, start_wr, stop_wr, trig, filt_en;
    logic [15:0] reload;
    logic [15:0] count_q;
    logic        enabled, irq;
    logic [15:0] exp_cnt;
    int          checks = 0;
    int          fails  = 0;

    always #5 clk = ~clk;

    edge_oneshot_timer u0 (
        .clk(clk), .rst(rst), .tick(tick), .start_wr(start_wr), .stop_wr(stop_wr),
        .reload(reload), .trig_async(trig), .filt_en(filt_en),
        .count_q(count_q), .enabled(enabled), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick = t;
        @(negedge clk);
        tick = 1'b0;
        start_wr = 1'b0;
        stop_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; start_wr = 1'b0; stop_wr = 1'b0;
        trig = 1'b0; filt_en = 1'b0; reload = 16'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 count", count_q, 16'h0000);
        chk("R1 enabled", enabled, 1'b0);
        chk("R1 irq", irq, 1'b0);

        // R2: arm and hold while waiting
        start_wr = 1'b1;
        cyc(1'b0);
        chk("R2 enabled", enabled, 1'b1);
        ticks(3);
        chk("R2 hold", count_q, 16'h0000);
        exp_cnt = 16'h0000;

        // vector table: R3/R6 latency, R4 decrement, R5 end, R9 restart, R11 zero
        for (int v = 0; v < NV; v++) begin
            filt_en = VEC[v].filt;
            reload  = VEC[v].rld;
            trig    = 1'b1;
            for (int k = 1; k <= int'(VEC[v].load_tk); k++) begin
                cyc(1'b1);
                if (k < int'(VEC[v].load_tk))
                    chk("R2 wait hold", count_q, exp_cnt);
                else if (VEC[v].filt)
                    chk("R6 filtered load", count_q, VEC[v].rld);
                else
                    chk("R3 R9 load", count_q, VEC[v].rld);
            end
            exp_cnt = VEC[v].rld;
            while (exp_cnt != 16'h0000) begin
                cyc(1'b1);
                exp_cnt = exp_cnt - 16'd1;
                chk("R4 decrement", count_q, exp_cnt);
            end
            cyc(1'b1);
            if (VEC[v].rld == 16'd0) chk("R11 zero reload irq", irq, 1'b1);
            else                     chk("R5 irq", irq, 1'b1);
            chk("R5 park", count_q, 16'hFFFF);
            chk("R5 enabled", enabled, 1'b1);
            cyc(1'b0);
            chk("R5 irq width", irq, 1'b0);
            chk("R4 hold", count_q, 16'hFFFF);
            trig = 1'b0;
            ticks(6);
            exp_cnt = 16'hFFFF;
            chk("R9 parked wait", count_q, exp_cnt);
        end

        // R7: one-tick glitch rejected by the filter
        filt_en = 1'b1;
        reload  = 16'd9;
        trig    = 1'b1;
        cyc(1'b1);
        trig = 1'b0;
        ticks(7);
        chk("R7 glitch", count_q, 16'hFFFF);
        chk("R7 irq", irq, 1'b0);

        // R10: stop freezes, restart needs a fresh edge
        filt_en = 1'b0;
        reload  = 16'd20;
        trig    = 1'b1;
        ticks(2);
        chk("R10 setup load", count_q, 16'd20);
        ticks(3);
        chk("R4 run", count_q, 16'd17);
        stop_wr = 1'b1;
        cyc(1'b0);
        chk("R10 enabled", enabled, 1'b0);
        chk("R10 frozen", count_q, 16'd17);
        trig = 1'b0;
        ticks(3);
        trig = 1'b1;
        ticks(4);
        chk("R10 ignore while off", count_q, 16'd17);
        start_wr = 1'b1;
        cyc(1'b0);
        chk("R10 rearm", enabled, 1'b1);
        ticks(5);
        chk("R10 no level trigger", count_q, 16'd17);
        trig = 1'b0;
        ticks(4);
        trig = 1'b1;
        ticks(2);
        chk("R10 fresh edge", count_q, 16'd20);

        // R12: start while running
        start_wr = 1'b1;
        cyc(1'b1);
        chk("R12 start ignored", count_q, 16'd19);
        chk("R12 enabled", enabled, 1'b1);

        // R8: edges during count ignored
        trig = 1'b0;
        ticks(3);
        trig = 1'b1;
        ticks(3);
        chk("R8 no restart", count_q, 16'd13);

        // R1: reset mid-count
        rst = 1'b1;
        cyc(1'b1);
        rst = 1'b0;
        chk("R1 mid count", count_q, 16'h0000);
        chk("R1 mid enabled", enabled, 1'b0);
        chk("R1 mid irq", irq, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule